// File: doc/BRIEF.md
# Audio Port Master Clock Generator

This block produces the bit clock and the left/right frame clock of a serial audio output port that runs as clock master, and it gates the port's serial data line. One of three free-running master clocks is chosen by a two-bit source field. The choice is made through a glitch-free handover, and all counting runs on the chosen clock. A two-bit divider field sets the ratio of master clock to frame clock at 128, 256, 384 or 512. The bit clock always runs at 64 periods per frame, so it divides the master clock by 2, 4, 6 or 8.

A new divider setting is taken only at a frame boundary, so no frame is ever cut short. The mute control is taken only on a falling bit-clock edge, so no bit in progress is cut short. When the source field holds the reserved code, the current clock stays in use and the port clocks never stop.

Top module: `audio_mclk_gen`

## Requirements
- R1: Divider code 00, 01, 10 and 11 gives a bit-clock period of 2, 4, 6 and 8 periods of the selected master clock. This is a frame ratio of 128, 256, 384 or 512.
- R2: The bit clock has a 50% duty cycle. It is high for exactly half of its period.
- R3: One frame clock period holds exactly 64 bit-clock periods. The frame clock is high for 32 of them, and each frame-clock edge coincides with a falling bit-clock edge.
- R4: While reset is active, the bit clock and the frame clock are low. After reset the block runs at divider code 00 from the primary master clock, with mute off.
- R5: Source code 00 selects the primary master clock, 01 selects the receiver input clock and 10 selects the recovered receiver clock.
- R6: Source code 11 is reserved. It keeps the source that was in use before, and the port clocks keep running.
- R7: A change of the divider code takes effect at the next falling frame-clock edge, which is the frame boundary. Until that edge, the bit clock keeps its old period.
- R8: With mute at 0, the serial data output follows the serial data input. With mute at 1, the output is held low.
- R9: A change of mute reaches the serial data output only at a falling bit-clock edge.
- R10: A source handover never yields a bit-clock high or low phase shorter than half a period of the fastest master clock, and at most one source drives the clock at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous reset, active low |
| mclk_main_i | input | 1 | Primary master clock (source code 00) |
| mclk_rx_in_i | input | 1 | Receiver input clock (source code 01) |
| mclk_rx_rec_i | input | 1 | Recovered receiver clock (source code 10) |
| src_sel_i | input | 2 | Master clock source field |
| div_sel_i | input | 2 | Master-to-frame ratio field |
| mute_i | input | 1 | Serial data mute, 1 forces the output low |
| sdata_i | input | 1 | Serial data from the upstream source |
| bclk_o | output | 1 | Bit clock |
| fclk_o | output | 1 | Left/right frame clock |
| sdata_o | output | 1 | Muted or passed serial data |

## Verification
The assertions assume that all three master clocks run freely, that reset is released while they run, and that the divider and source fields change slowly. A field must be held for several master-clock cycles so that the two-flop synchronizers never capture a torn code. The stimulus changes a field only once and then holds it for at least two full frames before it measures anything. The random draws use a fixed seed, and the directed cases time mute changes against bit-clock edges with the slowest divider. That divider leaves room for the synchronizer delay.

// File: rtl/amcg_pkg.sv
`timescale 1ns/1ps
package amcg_pkg;
  localparam int unsigned BASE_RATIO = 128;

  typedef enum logic [1:0] {
    SRC_MAIN   = 2'd0,
    SRC_RX_IN  = 2'd1,
    SRC_RX_REC = 2'd2,
    SRC_HOLD   = 2'd3
  } src_e;

  function automatic int unsigned ratio_of(input int unsigned code);
    return BASE_RATIO * (code + 1);
  endfunction
endpackage

// File: rtl/amcg_sync.sv
`timescale 1ns/1ps
module amcg_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/amcg_clk_switch.sv
`timescale 1ns/1ps
module amcg_clk_switch #(
  parameter int unsigned N_SRC = 3
) (
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] clk_i,
  input  logic [N_SRC-1:0] req_i,
  input  logic             hold_i,
  output logic             clk_o
);
  logic [N_SRC-1:0] en_q;
  logic [N_SRC-1:0] gated;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    localparam logic RV = (g == 0);
    localparam logic [N_SRC-1:0] SELF = N_SRC'(1) << g;
    logic want, st1_q, en_l;

    // hold keeps whichever branch is live; others must be off first
    assign want = (req_i[g] | (hold_i & en_l)) & ~|(en_q & ~SELF);

    always_ff @(posedge clk_i[g] or negedge rst_ni) begin
      if (!rst_ni) st1_q <= RV;
      else         st1_q <= want;
    end

    always_ff @(negedge clk_i[g] or negedge rst_ni) begin
      if (!rst_ni) en_l <= RV;
      else         en_l <= st1_q;
    end

    assign en_q[g]  = en_l;
    assign gated[g] = clk_i[g] & en_l;
  end

  assign clk_o = |gated;

  always_comb begin
    if (rst_ni) p_one_source_r10: assert ($onehot0(en_q));
  end
endmodule

// File: rtl/amcg_div.sv
`timescale 1ns/1ps
module amcg_div
  import amcg_pkg::*;
#(
  parameter int unsigned DIV_W          = 2,
  parameter int unsigned BITS_PER_FRAME = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_req_i,
  input  logic             mute_req_i,
  output logic             bclk_o,
  output logic             fclk_o,
  output logic             mute_o
);
  localparam int unsigned MAX_HALF = ratio_of(2**DIV_W - 1) / (2 * BITS_PER_FRAME);
  localparam int unsigned HALF_W   = (MAX_HALF > 1) ? $clog2(MAX_HALF) : 1;
  localparam int unsigned CNT_W    = $clog2(BITS_PER_FRAME);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BITS_PER_FRAME - 1);

  logic [DIV_W-1:0]  div_q;
  logic [HALF_W-1:0] hcnt_q, half_m1;
  logic [CNT_W-1:0]  bcnt_q, bcnt_inc;
  logic              bclk_q, fclk_q, mute_q;

  assign half_m1  = HALF_W'(ratio_of(32'(div_q)) / (2 * BITS_PER_FRAME) - 1);
  assign bcnt_inc = bcnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= '0;
      bclk_q <= 1'b0;
      bcnt_q <= '0;
      fclk_q <= 1'b0;
      div_q  <= '0;
      mute_q <= 1'b0;
    end else if (hcnt_q == half_m1) begin
      hcnt_q <= '0;
      bclk_q <= ~bclk_q;
      if (bclk_q) begin
        // falling bit-clock edge
        bcnt_q <= bcnt_inc;
        fclk_q <= bcnt_inc[CNT_W-1];
        mute_q <= mute_req_i;
        if (bcnt_q == LAST_BIT) div_q <= div_req_i;
      end
    end else begin
      hcnt_q <= hcnt_q + 1'b1;
    end
  end

  assign bclk_o = bclk_q;
  assign fclk_o = fclk_q;
  assign mute_o = mute_q;

  p_half_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hcnt_q <= half_m1);
  p_fclk_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(fclk_q) |-> $fell(bclk_q));
  p_div_boundary_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(div_q) |-> $fell(fclk_q));
  p_mute_edge_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mute_q) |-> $fell(bclk_q));
endmodule

// File: rtl/audio_mclk_gen.sv
`timescale 1ns/1ps
module audio_mclk_gen
  import amcg_pkg::*;
#(
  parameter int unsigned N_SRC          = 3,
  parameter int unsigned SEL_W          = 2,
  parameter int unsigned DIV_W          = 2,
  parameter int unsigned BITS_PER_FRAME = 64,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic             rst_ni,
  input  logic             mclk_main_i,
  input  logic             mclk_rx_in_i,
  input  logic             mclk_rx_rec_i,
  input  logic [SEL_W-1:0] src_sel_i,
  input  logic [DIV_W-1:0] div_sel_i,
  input  logic             mute_i,
  input  logic             sdata_i,
  output logic             bclk_o,
  output logic             fclk_o,
  output logic             sdata_o
);
  logic [N_SRC-1:0] clks, req;
  logic             hold, mclk_sel, mute_q, mute_s;
  logic [DIV_W-1:0] div_s;

  assign clks = {mclk_rx_rec_i, mclk_rx_in_i, mclk_main_i};

  for (genvar g = 0; g < N_SRC; g++) begin : g_dec
    assign req[g] = (src_sel_i == SEL_W'(g));
  end
  // codes past the last source are reserved: keep the current one
  assign hold = (src_sel_i >= SEL_W'(N_SRC));

  amcg_clk_switch #(.N_SRC(N_SRC)) u_switch (
    .rst_ni (rst_ni),
    .clk_i  (clks),
    .req_i  (req),
    .hold_i (hold),
    .clk_o  (mclk_sel)
  );

  amcg_sync #(.W(DIV_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_div_sync (
    .clk_i  (mclk_sel),
    .rst_ni (rst_ni),
    .d_i    (div_sel_i),
    .q_o    (div_s)
  );

  amcg_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_mute_sync (
    .clk_i  (mclk_sel),
    .rst_ni (rst_ni),
    .d_i    (mute_i),
    .q_o    (mute_s)
  );

  amcg_div #(.DIV_W(DIV_W), .BITS_PER_FRAME(BITS_PER_FRAME)) u_div (
    .clk_i      (mclk_sel),
    .rst_ni     (rst_ni),
    .div_req_i  (div_s),
    .mute_req_i (mute_s),
    .bclk_o     (bclk_o),
    .fclk_o     (fclk_o),
    .mute_o     (mute_q)
  );

  assign sdata_o = sdata_i & ~mute_q;
endmodule

// File: tb/audio_mclk_gen_bench.sv
`timescale 1ns/1ps
module audio_mclk_gen_bench;
  logic rst_ni = 1'b0;
  logic ma = 1'b0, mb = 1'b0, mc = 1'b0;
  logic [1:0] src_sel = 2'd0, div_sel = 2'd0;
  logic mute = 1'b0, sdata = 1'b0;
  logic bclk, fclk, sdo;

  int n_run = 0, n_fail = 0, bcnt_tb = 0, glitches = 0;
  realtime t_bfall = 0, t_frise = 0, t_bedge = 0;
  bit done = 0;

  always #2.5 ma = ~ma;   // 200 MHz primary
  always #3.5 mb = ~mb;
  always #5.5 mc = ~mc;

  audio_mclk_gen u_audio_mclk_gen (
    .rst_ni(rst_ni), .mclk_main_i(ma), .mclk_rx_in_i(mb), .mclk_rx_rec_i(mc),
    .src_sel_i(src_sel), .div_sel_i(div_sel), .mute_i(mute), .sdata_i(sdata),
    .bclk_o(bclk), .fclk_o(fclk), .sdata_o(sdo)
  );

  always @(posedge bclk) bcnt_tb++;
  always @(negedge bclk) t_bfall = $realtime;
  always @(posedge fclk) t_frise = $realtime;
  // R10: no short bit-clock phase, even across handovers
  always @(bclk) begin
    if (rst_ni && t_bedge > 0 && ($realtime - t_bedge) < 2.49) glitches++;
    t_bedge = $realtime;
  end

  function automatic real src_period(input int s);
    return (s == 0) ? 5.0 : (s == 1) ? 7.0 : 11.0;
  endfunction
  function automatic real exp_bclk(input int s, input int d);
    return 2.0 * (d + 1) * src_period(s);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input real act, input real exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
    end
  endtask

  function automatic bit near(input real a, input real b);
    return (a - b < 0.01) && (b - a < 0.01);
  endfunction

  task automatic settle();
    repeat (2) @(negedge fclk);
  endtask

  task automatic measure(input int s, input int d, input string req);
    realtime t0, t1, t2, tf, tn;
    real p;
    int c0, c1;
    p = exp_bclk(s, d);
    settle();
    @(posedge bclk); t0 = $realtime;
    @(negedge bclk); t1 = $realtime;
    @(posedge bclk); t2 = $realtime;
    chk(near(t2 - t0, p), req, "bclk period", t2 - t0, p);
    chk(near(t1 - t0, p / 2), "R2", "bclk high time", t1 - t0, p / 2);
    @(posedge fclk); #0.1; c0 = bcnt_tb; tf = t_frise;
    chk(near(tf, t_bfall), "R3", "fclk rise vs bclk fall", tf, t_bfall);
    @(negedge fclk); tn = $realtime;
    chk(near(tn - tf, 32 * p), "R3", "fclk high time", tn - tf, 32 * p);
    @(posedge fclk); #0.1; c1 = bcnt_tb;
    chk(c1 - c0 == 64, "R3", "bclk per frame", c1 - c0, 64);
  endtask

  initial begin
    #800_000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int cur;
    realtime t0, t1;
    void'($urandom(32'h5eed));
    sdata = 1'b1;
    #40;
    chk(bclk == 1'b0 && fclk == 1'b0, "R4", "clocks low in reset", bclk, 0);
    chk(sdo == 1'b1, "R4", "mute off in reset", sdo, 1);
    rst_ni = 1'b1;
    measure(0, 0, "R4");
    for (int d = 1; d < 4; d++) begin
      div_sel = 2'(d);
      measure(0, d, "R1");
    end
    div_sel = 2'd1;
    src_sel = 2'd1; measure(1, 1, "R5");
    src_sel = 2'd2; measure(2, 1, "R5");
    src_sel = 2'd3; measure(2, 1, "R6");
    src_sel = 2'd0; div_sel = 2'd0; measure(0, 0, "R5");
    src_sel = 2'd3; measure(0, 0, "R6");
    cur = 0;

    // R7: mid-frame divider change waits for the frame boundary
    src_sel = 2'd0; div_sel = 2'd0; settle();
    @(posedge fclk); #1; div_sel = 2'd3;
    repeat (3) @(posedge bclk);
    t0 = $realtime; @(posedge bclk); t1 = $realtime;
    chk(near(t1 - t0, 10.0), "R7", "old period before boundary", t1 - t0, 10.0);
    @(negedge fclk); t0 = $realtime;
    @(posedge bclk); t1 = $realtime;
    chk(near(t1 - t0, 20.0), "R7", "new low phase at boundary", t1 - t0, 20.0);
    t0 = t1; @(posedge bclk); t1 = $realtime;
    chk(near(t1 - t0, 40.0), "R7", "new period after boundary", t1 - t0, 40.0);

    // R8/R9: mute with half-period of 4 master clocks
    for (int k = 0; k < 6; k++) begin
      sdata = 1'($urandom); #1;
      chk(sdo == sdata, "R8", "pass when unmuted", sdo, sdata);
    end
    sdata = 1'b1;
    @(posedge bclk); #1; mute = 1'b1; #10;
    chk(sdo == 1'b1, "R9", "mute waits for bclk fall", sdo, 1);
    @(negedge bclk); #0.1;
    chk(sdo == 1'b0, "R8", "muted output low", sdo, 0);
    for (int k = 0; k < 4; k++) begin
      sdata = 1'($urandom); #3;
      chk(sdo == 1'b0, "R8", "muted stays low", sdo, 0);
    end
    sdata = 1'b1;
    @(posedge bclk); #1; mute = 1'b0; #10;
    chk(sdo == 1'b0, "R9", "unmute waits for bclk fall", sdo, 0);
    @(negedge bclk); #0.1;
    chk(sdo == 1'b1, "R8", "unmuted follows input", sdo, 1);

    // random source/divider mix
    for (int k = 0; k < 10; k++) begin
      int s, d;
      s = int'($urandom % 4);
      d = int'($urandom % 4);
      src_sel = 2'(s); div_sel = 2'(d);
      if (s != 3) cur = s;
      measure(cur, d, (s == 3) ? "R6" : "R1");
    end

    chk(glitches == 0, "R10", "short bclk phases", glitches, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule